// File: doc/BRIEF.md
# Locked-Sequence Address Override Controller

This block sits beside a CPU's decode and retire logic. It follows the prefix instructions that change how the next few instructions behave. A prefix event carries three things: a kind, a run length of one to four instructions, and a base value. The base value is used as a page number or as a segment number. From the cycle after the prefix is accepted, one countdown governs all of the prefix's effects. While the countdown is non-zero, interrupt acceptance is held off. Depending on the kind, 16-bit operand addresses are also mapped through the prefix's page or segment instead of the four page pointers, and short register or bit-offset accesses are steered into the extended register space.

The countdown drops by one for every retired instruction that is not itself a prefix. When it reaches zero, every effect is released on the following cycle. A prefix that arrives while a run is still active reloads the countdown and fully replaces the earlier effect. Chaining prefixes in this way builds locked sequences longer than four instructions.

Address translation is combinational from the operand address and the registered override state. The inhibit output and the space-select output follow the registered state.

Top module: `lock_seq_ctrl`

## Requirements
- R1: During and straight after reset, `lock_left` is 0, `irq_inhibit` is 0 and `ext_space` is 0, and addresses use normal translation.
- R2: With no run active, `phys_addr` = {pointer[op_addr[15:14]], op_addr[13:0]}. Pointer n occupies `dpp_flat[10n+9:10n]`.
- R3: Kinds 1 (page) and 4 (page plus redirect) make `phys_addr` = {`pfx_base`[9:0], op_addr[13:0]} while their run is active.
- R4: Kinds 2 (segment) and 5 (segment plus redirect) make `phys_addr` = {`pfx_base`[7:0], op_addr[15:0]} while their run is active. Segment 15 therefore spans 0F0000h to 0FFFFFh.
- R5: Kinds 3 (redirect), 4 and 5 make `ext_space` equal to `short_acc` while their run is active. At all other times `ext_space` is 0.
- R6: An accepted prefix loads `lock_left` with `pfx_len`+1 (1 to 4). Each `retire` pulse then lowers it by one until it reaches 0.
- R7: Every accepted kind, including kind 0 (atomic), raises `irq_inhibit` from the next cycle. `irq_inhibit` falls in the cycle after the retire that takes `lock_left` to 0, and the overrides are released at the same time.
- R8: A prefix accepted during an active run reloads the count and replaces the override kind. An atomic prefix clears every override and keeps interrupts inhibited.
- R9: When a prefix and a retire arrive in the same cycle, the prefix load wins and no decrement happens.
- R10: Kind codes 6 and 7 are ignored. They leave `lock_left`, `irq_inhibit`, `ext_space` and `phys_addr` unchanged.
- R11: A retire with no run active leaves `lock_left` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_valid | input | 1 | A prefix instruction is decoded this cycle |
| pfx_kind | input | 3 | Prefix kind code, 0 to 5 valid |
| pfx_len | input | 2 | Run length minus one |
| pfx_base | input | 10 | Page number, or segment number in the low 8 bits |
| retire | input | 1 | A non-prefix instruction retires this cycle |
| dpp_flat | input | 40 | Four packed 10-bit page pointers |
| op_addr | input | 16 | Operand address to translate |
| short_acc | input | 1 | The current access uses short register addressing |
| phys_addr | output | 24 | Translated physical data address |
| ext_space | output | 1 | Short access goes to the extended register space |
| irq_inhibit | output | 1 | Interrupt acceptance is held off |
| lock_left | output | 3 | Instructions left in the locked run |

## Verification
The assertions check the following on every cycle:
- the countdown load after an accepted prefix, and the single-step decrement on a retire;
- load priority when a prefix and a retire coincide;
- that unknown kinds and idle cycles leave the count unchanged;
- that the redirect is never seen without the inhibit.

Only the bench's scenarios can show the translated addresses. The bench sweeps every kind and every length, with addresses chosen at each pointer-select boundary. Nested reloads, the atomic clearing of overrides and the exact segment 15 window are likewise checked by comparing outputs against the bench's arithmetic.

// File: rtl/lso_pkg.sv
package lso_pkg;

  // Prefix kind codes on the pfx_kind input.
  typedef enum logic [2:0] {
    PFX_ATOMIC   = 3'd0,
    PFX_PAGE     = 3'd1,
    PFX_SEG      = 3'd2,
    PFX_REG      = 3'd3,
    PFX_PAGE_REG = 3'd4,
    PFX_SEG_REG  = 3'd5
  } pfx_kind_e;

  // Effects implied by one prefix kind.
  typedef struct packed {
    logic known;
    logic page_ovr;
    logic seg_ovr;
    logic reg_redir;
  } pfx_effect_t;

  function automatic pfx_effect_t decode_prefix(input logic [2:0] kind);
    pfx_effect_t e;
    e = '0;
    case (kind)
      PFX_ATOMIC:   e.known = 1'b1;
      PFX_PAGE:     begin e.known = 1'b1; e.page_ovr = 1'b1; end
      PFX_SEG:      begin e.known = 1'b1; e.seg_ovr = 1'b1; end
      PFX_REG:      begin e.known = 1'b1; e.reg_redir = 1'b1; end
      PFX_PAGE_REG: begin e.known = 1'b1; e.page_ovr = 1'b1; e.reg_redir = 1'b1; end
      PFX_SEG_REG:  begin e.known = 1'b1; e.seg_ovr = 1'b1; e.reg_redir = 1'b1; end
      default:      e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/lso_countdown.sv
module lso_countdown #(
  parameter int LEN_W = 2,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             expire
);

  // Encoded length n means n+1 instructions.
  function automatic logic [CNT_W-1:0] run_of(input logic [LEN_W-1:0] len);
    return {{(CNT_W-LEN_W){1'b0}}, len} + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= run_of(load_len);
    else if (dec && (cnt != '0))
      cnt <= cnt - CNT_W'(1);
  end

  assign active = (cnt != '0);
  // Last instruction of the run retires this cycle.
  assign expire = dec && !load && (cnt == CNT_W'(1));

endmodule

// File: rtl/lso_mode_reg.sv
module lso_mode_reg
  import lso_pkg::*;
#(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  pfx_effect_t       eff,
  input  logic [PAGE_W-1:0] base,
  input  logic              clear,
  output logic              page_on,
  output logic              seg_on,
  output logic              redir_on,
  output logic [PAGE_W-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_on  <= 1'b0;
      seg_on   <= 1'b0;
      redir_on <= 1'b0;
      base_q   <= '0;
    end else if (load) begin
      // A new prefix replaces the previous override completely.
      page_on  <= eff.page_ovr;
      seg_on   <= eff.seg_ovr;
      redir_on <= eff.reg_redir;
      base_q   <= base;
    end else if (clear) begin
      page_on  <= 1'b0;
      seg_on   <= 1'b0;
      redir_on <= 1'b0;
    end
  end

endmodule

// File: rtl/lso_xlate.sv
module lso_xlate #(
  parameter int ADDR_W  = 16,
  parameter int OFS_W   = 14,
  parameter int PAGE_W  = 10,
  parameter int NUM_PTR = 4,
  parameter int PHYS_W  = PAGE_W + OFS_W
) (
  input  logic [NUM_PTR*PAGE_W-1:0] dpp_flat,
  input  logic [ADDR_W-1:0]         op_addr,
  input  logic                      page_on,
  input  logic                      seg_on,
  input  logic [PAGE_W-1:0]         base,
  output logic [PHYS_W-1:0]         phys
);

  localparam int SEL_W = ADDR_W - OFS_W;
  localparam int SEG_W = PHYS_W - ADDR_W;

  logic [PAGE_W-1:0] ptr [NUM_PTR];
  logic [SEL_W-1:0]  sel;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    assign ptr[g] = dpp_flat[g*PAGE_W +: PAGE_W];
  end

  function automatic logic [PHYS_W-1:0] join_page(input logic [PAGE_W-1:0] pg,
                                                  input logic [ADDR_W-1:0] a);
    return {pg, a[OFS_W-1:0]};
  endfunction

  function automatic logic [PHYS_W-1:0] join_seg(input logic [SEG_W-1:0] sg,
                                                 input logic [ADDR_W-1:0] a);
    return {sg, a};
  endfunction

  assign sel = op_addr[ADDR_W-1 -: SEL_W];

  always_comb begin
    if (page_on)
      phys = join_page(base, op_addr);
    else if (seg_on)
      phys = join_seg(base[SEG_W-1:0], op_addr);
    else
      phys = join_page(ptr[sel], op_addr);
  end

endmodule

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
  import lso_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFS_W   = 14,
  parameter int PAGE_W  = 10,
  parameter int NUM_PTR = 4,
  parameter int LEN_W   = 2,
  localparam int PHYS_W = PAGE_W + OFS_W,
  localparam int CNT_W  = LEN_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pfx_valid,
  input  logic [2:0]                pfx_kind,
  input  logic [LEN_W-1:0]          pfx_len,
  input  logic [PAGE_W-1:0]         pfx_base,
  input  logic                      retire,
  input  logic [NUM_PTR*PAGE_W-1:0] dpp_flat,
  input  logic [ADDR_W-1:0]         op_addr,
  input  logic                      short_acc,
  output logic [PHYS_W-1:0]         phys_addr,
  output logic                      ext_space,
  output logic                      irq_inhibit,
  output logic [CNT_W-1:0]          lock_left
);

  pfx_effect_t       eff;
  logic              pfx_accept;
  logic              step;
  logic              run_active;
  logic              run_expire;
  logic              page_on, seg_on, redir_on;
  logic [PAGE_W-1:0] base_q;

  assign eff        = decode_prefix(pfx_kind);
  assign pfx_accept = pfx_valid && eff.known;
  assign step       = retire && !pfx_accept;

  lso_countdown #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pfx_accept),
    .load_len (pfx_len),
    .dec      (step),
    .cnt      (lock_left),
    .active   (run_active),
    .expire   (run_expire)
  );

  lso_mode_reg #(.PAGE_W(PAGE_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pfx_accept),
    .eff      (eff),
    .base     (pfx_base),
    .clear    (run_expire),
    .page_on  (page_on),
    .seg_on   (seg_on),
    .redir_on (redir_on),
    .base_q   (base_q)
  );

  lso_xlate #(
    .ADDR_W (ADDR_W), .OFS_W(OFS_W), .PAGE_W(PAGE_W),
    .NUM_PTR(NUM_PTR), .PHYS_W(PHYS_W)
  ) u_xl (
    .dpp_flat (dpp_flat),
    .op_addr  (op_addr),
    .page_on  (page_on && run_active),
    .seg_on   (seg_on && run_active),
    .base     (base_q),
    .phys     (phys_addr)
  );

  assign irq_inhibit = run_active;
  assign ext_space   = short_acc && redir_on && run_active;

endmodule

// File: rtl/lso_checker.sv
module lso_checker #(
  parameter int LEN_W = 2,
  parameter int CNT_W = LEN_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pfx_valid,
  input logic [2:0]       pfx_kind,
  input logic [LEN_W-1:0] pfx_len,
  input logic             retire,
  input logic             pfx_accept,
  input logic [CNT_W-1:0] lock_left,
  input logic             irq_inhibit,
  input logic             ext_space
);

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_accept |=> lock_left == ({1'b0, $past(pfx_len)} + CNT_W'(1)));

  assert_inhibit_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_accept |=> irq_inhibit);

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !pfx_accept && lock_left != '0) |=> lock_left == $past(lock_left) - CNT_W'(1));

  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !pfx_accept && lock_left == CNT_W'(1)) |=> !irq_inhibit);

  assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && pfx_accept) |=> lock_left == ({1'b0, $past(pfx_len)} + CNT_W'(1)));

  assert_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_valid && pfx_kind > 3'd5 && !retire) |=> ($stable(lock_left) && $stable(irq_inhibit)));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !pfx_valid) |=> $stable(lock_left));

  assert_redir_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_inhibit |-> !ext_space);

endmodule

bind lock_seq_ctrl lso_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pfx_valid   (pfx_valid),
  .pfx_kind    (pfx_kind),
  .pfx_len     (pfx_len),
  .retire      (retire),
  .pfx_accept  (pfx_accept),
  .lock_left   (lock_left),
  .irq_inhibit (irq_inhibit),
  .ext_space   (ext_space)
);

// File: tb/sim_lock_seq_ctrl.sv
module sim_lock_seq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pfx_valid = 1'b0;
  logic [2:0]  pfx_kind = '0;
  logic [1:0]  pfx_len = '0;
  logic [9:0]  pfx_base = '0;
  logic        retire = 1'b0;
  logic [9:0]  dpp_v [4];
  logic [39:0] dpp_flat;
  logic [15:0] op_addr = '0;
  logic        short_acc = 1'b0;
  logic [23:0] phys_addr;
  logic        ext_space;
  logic        irq_inhibit;
  logic [2:0]  lock_left;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model state.
  int         mcnt = 0;
  bit         mpg = 0, msg = 0, mrr = 0;
  logic [9:0] mbase = '0;

  logic [15:0] addrs [8] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF,
                             16'h8001, 16'hBFFF, 16'hC000, 16'hFFFF};

  assign dpp_flat = {dpp_v[3], dpp_v[2], dpp_v[1], dpp_v[0]};

  always #(CLK_P/2) clk = ~clk;

  lock_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_kind(pfx_kind),
    .pfx_len(pfx_len), .pfx_base(pfx_base), .retire(retire),
    .dpp_flat(dpp_flat), .op_addr(op_addr), .short_acc(short_acc),
    .phys_addr(phys_addr), .ext_space(ext_space),
    .irq_inhibit(irq_inhibit), .lock_left(lock_left)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [23:0] exp_phys(input logic [15:0] a);
    if (mpg && mcnt > 0) return {mbase, a[13:0]};
    if (msg && mcnt > 0) return {mbase[7:0], a};
    return {dpp_v[a[15:14]], a[13:0]};
  endfunction

  task automatic check_all(input string req);
    chk({req, " lock_left"}, 32'(lock_left), 32'(mcnt));
    chk({req, " irq_inhibit"}, 32'(irq_inhibit), 32'(mcnt != 0));
    for (int i = 0; i < 8; i++) begin
      op_addr = addrs[i];
      short_acc = 1'b0;
      #1;
      chk({req, " phys_addr"}, 32'(phys_addr), 32'(exp_phys(addrs[i])));
      short_acc = 1'b1;
      #1;
      chk({req, " ext_space"}, 32'(ext_space), 32'(mrr && mcnt > 0));
    end
    short_acc = 1'b0;
  endtask

  // One clock: drive on the falling edge, update the model at the rising edge.
  task automatic tick(input bit pv, input logic [2:0] k, input logic [1:0] len,
                      input logic [9:0] base, input bit ret);
    @(negedge clk);
    pfx_valid = pv; pfx_kind = k; pfx_len = len; pfx_base = base; retire = ret;
    @(posedge clk);
    if (pv && k <= 3'd5) begin
      mcnt  = int'(len) + 1;
      mpg   = (k == 3'd1) || (k == 3'd4);
      msg   = (k == 3'd2) || (k == 3'd5);
      mrr   = (k == 3'd3) || (k == 3'd4) || (k == 3'd5);
      mbase = base;
    end else if (ret && mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) begin mpg = 0; msg = 0; mrr = 0; end
    end
    #1;
    pfx_valid = 1'b0; retire = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R7 atomic";
      3'd1, 3'd4: return "R3 page";
      3'd2, 3'd5: return "R4 seg";
      3'd3: return "R5 redirect";
      default: return "R10 unknown";
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    dpp_v[0] = 10'h2A5; dpp_v[1] = 10'h13C; dpp_v[2] = 10'h3FF; dpp_v[3] = 10'h001;
    // R1: reset holds everything idle even with a prefix on the inputs.
    pfx_valid = 1'b1; pfx_kind = 3'd4; pfx_len = 2'd3; retire = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    pfx_valid = 1'b0; retire = 1'b0;
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 after reset");

    // R2 with two pointer sets; R11 retire with no run.
    check_all("R2 normal");
    dpp_v[0] = 10'h055; dpp_v[1] = 10'h3C3; dpp_v[2] = 10'h100; dpp_v[3] = 10'h2EE;
    check_all("R2 normal set2");
    tick(0, 3'd0, 2'd0, 10'd0, 1);
    check_all("R11 idle retire");
    tick(0, 3'd0, 2'd0, 10'd0, 1);
    check_all("R11 idle retire 2");

    // Sweep every kind and every length; R6 countdown, R7 release.
    for (int k = 0; k < 8; k++) begin
      for (int len = 0; len < 4; len++) begin
        tick(1, 3'(k), 2'(len), 10'(10'h0A7 + k * 73 + len * 29), 0);
        check_all(tag_of(3'(k)));
        for (int r = 0; r <= len; r++) begin
          tick(0, 3'd0, 2'd0, 10'd0, 1);
          check_all("R6 R7 countdown");
        end
      end
    end

    // R4: segment 15 window.
    tick(1, 3'd2, 2'd0, 10'd15, 0);
    op_addr = 16'h0000; #1;
    chk("R4 seg15 low", 32'(phys_addr), 32'h0F0000);
    op_addr = 16'hFFFF; #1;
    chk("R4 seg15 high", 32'(phys_addr), 32'h0FFFFF);
    tick(0, 3'd0, 2'd0, 10'd0, 1);
    check_all("R7 seg15 release");

    // R8: nested reloads and atomic clearing.
    tick(1, 3'd1, 2'd1, 10'h155, 0);
    tick(0, 3'd0, 2'd0, 10'd0, 1);
    check_all("R8 page mid");
    tick(1, 3'd5, 2'd2, 10'h0A3, 0);
    check_all("R8 nested seg");
    tick(0, 3'd0, 2'd0, 10'd0, 1);
    tick(1, 3'd0, 2'd0, 10'h3FF, 0);
    check_all("R8 atomic clears");
    tick(1, 3'd0, 2'd3, 10'h000, 0);
    check_all("R8 atomic extends");
    for (int r = 0; r < 4; r++) begin
      tick(0, 3'd0, 2'd0, 10'd0, 1);
      check_all("R8 long run");
    end

    // R9: simultaneous prefix and retire.
    tick(1, 3'd3, 2'd0, 10'h011, 0);
    tick(1, 3'd4, 2'd3, 10'h2C1, 1);
    check_all("R9 prefix wins");

    // R10: unknown kinds inside an active run.
    tick(1, 3'd6, 2'd0, 10'h3AA, 0);
    check_all("R10 kind6 in run");
    tick(1, 3'd7, 2'd1, 10'h155, 1);
    check_all("R10 kind7 with retire");
    for (int r = 0; r < 3; r++) begin
      tick(0, 3'd0, 2'd0, 10'd0, 1);
      check_all("R6 drain");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule